// File: doc/BRIEF.md
# Serial Port FIFO Status and Interrupt Controller

This block keeps the status flags and the line-status overrun flag of a FIFO-based serial port. It also holds a small FIFO control register and drives four interrupt lines: receive data, transmit data, break and receive error. The shifters, baud generator and FIFO storage sit outside the block. They show up here only as occupancy counts, trigger levels and single-cycle event strobes.

Software clears a flag by writing 0 to its bit. A bit written as 1 is left as it is. A flag whose cause is still present cannot be cleared: a non-empty transmit queue holds the transmit-end flag, an occupancy on the wrong side of a trigger level holds the level flags, and a non-empty receive queue holds data-ready. A hardware event that arrives in the same cycle as a clearing write wins, and the flag stays set.

Each interrupt line follows its flags only while its enable is high. While the enable is low the line holds its last value. It therefore drops only once every flag feeding it is clear and the enable is set. Writing the FIFO control register with its receive-reset bit set empties the receive side: it pulses a flush strobe to the storage, and it clears data-ready and receive-full even while their causes are still present.

Top module: `usfc_status_ctrl`

## Requirements
- R1: After reset the status register reads 0x60 (transmit-end and transmit-empty set), and the overrun flag, the FIFO control register, the flush strobe and all four interrupt lines are 0.
- R2: A write to the status register (address 0) leaves every bit written as 1 unchanged and clears every bit written as 0, unless that bit is held or set in the same cycle. Bit map: 7 error summary, 6 transmit-end, 5 transmit-empty, 4 break, 3 framing error, 2 parity error, 1 receive-full, 0 data-ready. A framing or parity event sets its own bit and bit 7, and a break event sets bit 4.
- R3: Transmit-end (bit 6) sets when the transmit count falls from non-zero to zero. A write of 0 does not clear it while the transmit count is non-zero.
- R4: Transmit-empty (bit 5) is set while the transmit count is at or below the transmit trigger level, and a write of 0 cannot clear it then. With the count above the level, a write of 0 clears it.
- R5: Receive-full (bit 1) is set while the receive count is non-zero and at or above the receive trigger level, and a write of 0 cannot clear it then.
- R6: Data-ready (bit 0) is set by a receive-timeout event. A write of 0 does not clear it while the receive count is non-zero.
- R7: When a hardware event and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R8: The overrun flag (address 1, bit 0) sets on an overrun event. Writing 0 to bit 0 clears it unless an overrun event arrives in that cycle. Writing 1 has no effect.
- R9: A write to the FIFO control register (address 2) stores the low 4 bits. If bit 1 is set, the next cycle shows data-ready and receive-full cleared, even if their causes are still present, and a one-cycle flush strobe.
- R10: While the receive enable is high, the receive interrupt equals data-ready OR receive-full. While it is low, the line holds its value.
- R11: While the transmit enable is high, the transmit interrupt equals transmit-empty. While it is low, the line holds its value.
- R12: While the error enable is high, the break interrupt equals the break flag, and the error interrupt equals the error summary flag OR the overrun flag. While the error enable is low, both lines hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| tx_trig | input | CNT_W | Transmit trigger level |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| rx_trig | input | CNT_W | Receive trigger level |
| rx_tmo_evt | input | 1 | Receive timeout strobe (sets data-ready) |
| brk_evt | input | 1 | Break detected strobe |
| fer_evt | input | 1 | Framing error strobe |
| per_evt | input | 1 | Parity error strobe |
| ovr_evt | input | 1 | Receive overrun strobe |
| tx_ie | input | 1 | Transmit interrupt enable |
| rx_ie | input | 1 | Receive interrupt enable |
| err_ie | input | 1 | Break and error interrupt enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 status, 1 line status, 2 FIFO control |
| wr_data | input | 8 | Write data or mask |
| status_o | output | 8 | Status register |
| line_o | output | 1 | Overrun flag |
| fctl_o | output | FCTL_W | FIFO control register |
| rx_flush_o | output | 1 | One-cycle receive flush strobe |
| irq_rx_o | output | 1 | Receive data interrupt |
| irq_tx_o | output | 1 | Transmit data interrupt |
| irq_brk_o | output | 1 | Break interrupt |
| irq_err_o | output | 1 | Receive error interrupt |

## Verification
The bench builds the block with its defaults: a FIFO depth of 16, which gives 5-bit counts, and a 4-bit FIFO control register whose bit 1 requests the flush. With these widths the bench can drive counts above, at and below any trigger level, and a receive occupancy that stays non-zero during a flush. That lets it show each holding rule both while the cause is present and after it has gone. The directed sequences also place an event and a clearing write in the same cycle, and they toggle each enable between the raising and the clearing of a flag, so the frozen interrupt state can be seen at the pins.

// File: rtl/usfc_pkg.sv
package usfc_pkg;

   localparam int ST_W = 8;

   // status bit positions
   localparam int B_DR   = 0;
   localparam int B_RDF  = 1;
   localparam int B_PER  = 2;
   localparam int B_FER  = 3;
   localparam int B_BRK  = 4;
   localparam int B_TDFE = 5;
   localparam int B_TEND = 6;
   localparam int B_ER   = 7;

   typedef enum logic [1:0] {
      RA_STAT = 2'd0,
      RA_LINE = 2'd1,
      RA_FCTL = 2'd2,
      RA_NONE = 2'd3
   } reg_addr_e;

   localparam logic [ST_W-1:0] ST_RST = 8'h60;

   // flags emptied by a receive flush
   function automatic bit rx_side(input int b);
      return (b == B_DR) || (b == B_RDF);
   endfunction

endpackage

// File: rtl/usfc_flag_cell.sv
module usfc_flag_cell #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic keep_i,
   input  logic flush_i,
   output logic d_o,
   output logic q_o
);

   // flush beats set, set beats a software clear, keep vetoes the clear
   always_comb begin
      if (flush_i)
         d_o = 1'b0;
      else if (set_i)
         d_o = 1'b1;
      else if (clr_i && !keep_i)
         d_o = 1'b0;
      else
         d_o = q_o;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q_o <= RST_VAL;
      else
         q_o <= d_o;
   end

endmodule

// File: rtl/usfc_irq_hold.sv
module usfc_irq_hold (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic src_i,
   output logic irq_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         irq_o <= 1'b0;
      else if (en_i)
         irq_o <= src_i;
   end

endmodule

// File: rtl/usfc_line_ctrl.sv
module usfc_line_ctrl #(
   parameter int FCTL_W    = 4,
   parameter int FLUSH_BIT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_line_i,
   input  logic              wr_fctl_i,
   input  logic              line_bit_i,
   input  logic [FCTL_W-1:0] fctl_data_i,
   input  logic              ovr_evt_i,
   output logic              orer_d_o,
   output logic              orer_q_o,
   output logic [FCTL_W-1:0] fctl_o,
   output logic              flush_req_o,
   output logic              rx_flush_o
);

   assign flush_req_o = wr_fctl_i && fctl_data_i[FLUSH_BIT];

   always_comb begin
      if (ovr_evt_i)
         orer_d_o = 1'b1;
      else if (wr_line_i && !line_bit_i)
         orer_d_o = 1'b0;
      else
         orer_d_o = orer_q_o;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         orer_q_o   <= 1'b0;
         fctl_o     <= '0;
         rx_flush_o <= 1'b0;
      end else begin
         orer_q_o   <= orer_d_o;
         rx_flush_o <= flush_req_o;
         if (wr_fctl_i)
            fctl_o <= fctl_data_i;
      end
   end

endmodule

// File: rtl/usfc_status_ctrl.sv
module usfc_status_ctrl
   import usfc_pkg::*;
#(
   parameter  int FIFO_DEPTH = 16,
   parameter  int FCTL_W     = 4,
   parameter  int FLUSH_BIT  = 1,
   localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  tx_count,
   input  logic [CNT_W-1:0]  tx_trig,
   input  logic [CNT_W-1:0]  rx_count,
   input  logic [CNT_W-1:0]  rx_trig,
   input  logic              rx_tmo_evt,
   input  logic              brk_evt,
   input  logic              fer_evt,
   input  logic              per_evt,
   input  logic              ovr_evt,
   input  logic              tx_ie,
   input  logic              rx_ie,
   input  logic              err_ie,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [ST_W-1:0]   wr_data,
   output logic [ST_W-1:0]   status_o,
   output logic              line_o,
   output logic [FCTL_W-1:0] fctl_o,
   output logic              rx_flush_o,
   output logic              irq_rx_o,
   output logic              irq_tx_o,
   output logic              irq_brk_o,
   output logic              irq_err_o
);

   // elaboration-time parameter checks
   if (FIFO_DEPTH < 2) begin : g_bad_depth
      $error("usfc_status_ctrl: FIFO_DEPTH must be at least 2");
   end
   if (FCTL_W < 1 || FCTL_W > ST_W) begin : g_bad_fctl
      $error("usfc_status_ctrl: FCTL_W must lie in 1..8");
   end
   if (FLUSH_BIT < 0 || FLUSH_BIT >= FCTL_W) begin : g_bad_flush
      $error("usfc_status_ctrl: FLUSH_BIT must index FCTL_W");
   end

   logic wr_stat, wr_line, wr_fctl;
   assign wr_stat = wr_en && (wr_addr == RA_STAT);
   assign wr_line = wr_en && (wr_addr == RA_LINE);
   assign wr_fctl = wr_en && (wr_addr == RA_FCTL);

   // transmit drain edge detection
   logic tx_was_busy;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tx_was_busy <= 1'b0;
      else
         tx_was_busy <= (tx_count != '0);
   end

   logic tx_nz, rx_nz, tx_lvl, rx_lvl, tend_edge;
   assign tx_nz     = (tx_count != '0);
   assign rx_nz     = (rx_count != '0);
   assign tx_lvl    = (tx_count <= tx_trig);
   assign rx_lvl    = rx_nz && (rx_count >= rx_trig);
   assign tend_edge = tx_was_busy && !tx_nz;

   // line status and FIFO control
   logic orer_d, flush_req;
   usfc_line_ctrl #(
      .FCTL_W    (FCTL_W),
      .FLUSH_BIT (FLUSH_BIT)
   ) u_line (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_line_i   (wr_line),
      .wr_fctl_i   (wr_fctl),
      .line_bit_i  (wr_data[0]),
      .fctl_data_i (wr_data[FCTL_W-1:0]),
      .ovr_evt_i   (ovr_evt),
      .orer_d_o    (orer_d),
      .orer_q_o    (line_o),
      .fctl_o      (fctl_o),
      .flush_req_o (flush_req),
      .rx_flush_o  (rx_flush_o)
   );

   // per-bit set and hold sources
   logic [ST_W-1:0] set_v, keep_v, clr_v, flush_v, st_d;

   always_comb begin
      set_v         = '0;
      set_v[B_DR]   = rx_tmo_evt;
      set_v[B_RDF]  = rx_lvl;
      set_v[B_PER]  = per_evt;
      set_v[B_FER]  = fer_evt;
      set_v[B_BRK]  = brk_evt;
      set_v[B_TDFE] = tx_lvl;
      set_v[B_TEND] = tend_edge;
      set_v[B_ER]   = fer_evt || per_evt;

      keep_v         = '0;
      keep_v[B_DR]   = rx_nz;
      keep_v[B_RDF]  = rx_lvl;
      keep_v[B_TDFE] = tx_lvl;
      keep_v[B_TEND] = tx_nz;
   end

   assign clr_v = wr_stat ? ~wr_data : '0;

   for (genvar i = 0; i < ST_W; i++) begin : g_flag
      if (rx_side(i)) begin : g_rx
         assign flush_v[i] = flush_req;
      end else begin : g_other
         assign flush_v[i] = 1'b0;
      end

      usfc_flag_cell #(
         .RST_VAL (ST_RST[i])
      ) u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .set_i   (set_v[i]),
         .clr_i   (clr_v[i]),
         .keep_i  (keep_v[i]),
         .flush_i (flush_v[i]),
         .d_o     (st_d[i]),
         .q_o     (status_o[i])
      );
   end

   // interrupt lines follow next-state flags while enabled
   usfc_irq_hold u_irq_rx (
      .clk   (clk),
      .rst_n (rst_n),
      .en_i  (rx_ie),
      .src_i (st_d[B_DR] || st_d[B_RDF]),
      .irq_o (irq_rx_o)
   );

   usfc_irq_hold u_irq_tx (
      .clk   (clk),
      .rst_n (rst_n),
      .en_i  (tx_ie),
      .src_i (st_d[B_TDFE]),
      .irq_o (irq_tx_o)
   );

   usfc_irq_hold u_irq_brk (
      .clk   (clk),
      .rst_n (rst_n),
      .en_i  (err_ie),
      .src_i (st_d[B_BRK]),
      .irq_o (irq_brk_o)
   );

   usfc_irq_hold u_irq_err (
      .clk   (clk),
      .rst_n (rst_n),
      .en_i  (err_ie),
      .src_i (st_d[B_ER] || orer_d),
      .irq_o (irq_err_o)
   );

endmodule

// File: rtl/usfc_status_ctrl_chk.sv
module usfc_status_ctrl_chk #(
   parameter int CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] tx_count,
   input logic [CNT_W-1:0] tx_trig,
   input logic [CNT_W-1:0] rx_count,
   input logic             fer_evt,
   input logic             ovr_evt,
   input logic             tx_ie,
   input logic             rx_ie,
   input logic             err_ie,
   input logic             wr_en,
   input logic [1:0]       wr_addr,
   input logic [7:0]       wr_data,
   input logic [7:0]       status_o,
   input logic             line_o,
   input logic             rx_flush_o,
   input logic             irq_rx_o,
   input logic             irq_tx_o,
   input logic             irq_brk_o,
   input logic             irq_err_o
);

   logic flush_w;
   assign flush_w = wr_en && (wr_addr == 2'd2) && wr_data[1];

   AST_TEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o[6] && tx_count != '0) |=> status_o[6]); // R3

   AST_TDFE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_count <= tx_trig) |=> status_o[5]); // R4

   AST_DR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o[0] && rx_count != '0 && !flush_w) |=> status_o[0]); // R6

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      fer_evt |=> (status_o[3] && status_o[7])); // R7

   AST_LINE_NO_SELF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovr_evt && !line_o) |=> !line_o); // R8

   AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      flush_w |=> (status_o[1:0] == 2'b00 && rx_flush_o)); // R9

   AST_RX_IRQ_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_ie |=> $stable(irq_rx_o)); // R10

   AST_TX_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ie |=> (irq_tx_o == status_o[5])); // R11

   AST_ERR_IRQ_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !err_ie |=> ($stable(irq_brk_o) && $stable(irq_err_o))); // R12

endmodule

bind usfc_status_ctrl usfc_status_ctrl_chk #(
   .CNT_W (CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tx_count   (tx_count),
   .tx_trig    (tx_trig),
   .rx_count   (rx_count),
   .fer_evt    (fer_evt),
   .ovr_evt    (ovr_evt),
   .tx_ie      (tx_ie),
   .rx_ie      (rx_ie),
   .err_ie     (err_ie),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .wr_data    (wr_data),
   .status_o   (status_o),
   .line_o     (line_o),
   .rx_flush_o (rx_flush_o),
   .irq_rx_o   (irq_rx_o),
   .irq_tx_o   (irq_tx_o),
   .irq_brk_o  (irq_brk_o),
   .irq_err_o  (irq_err_o)
);

// File: tb/usfc_status_ctrl_bench.sv
module usfc_status_ctrl_bench;

   localparam int CNT_W  = 5;
   localparam int FCTL_W = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [CNT_W-1:0]  tx_count = '0, tx_trig = '0, rx_count = '0, rx_trig = 5'd1;
   logic              rx_tmo_evt = 0, brk_evt = 0, fer_evt = 0, per_evt = 0, ovr_evt = 0;
   logic              tx_ie = 0, rx_ie = 0, err_ie = 0;
   logic              wr_en = 0;
   logic [1:0]        wr_addr = '0;
   logic [7:0]        wr_data = '0;
   logic [7:0]        status_o;
   logic              line_o;
   logic [FCTL_W-1:0] fctl_o;
   logic              rx_flush_o, irq_rx_o, irq_tx_o, irq_brk_o, irq_err_o;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #5 clk = ~clk;

   usfc_status_ctrl u_usfc_status_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .tx_count   (tx_count),
      .tx_trig    (tx_trig),
      .rx_count   (rx_count),
      .rx_trig    (rx_trig),
      .rx_tmo_evt (rx_tmo_evt),
      .brk_evt    (brk_evt),
      .fer_evt    (fer_evt),
      .per_evt    (per_evt),
      .ovr_evt    (ovr_evt),
      .tx_ie      (tx_ie),
      .rx_ie      (rx_ie),
      .err_ie     (err_ie),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .status_o   (status_o),
      .line_o     (line_o),
      .fctl_o     (fctl_o),
      .rx_flush_o (rx_flush_o),
      .irq_rx_o   (irq_rx_o),
      .irq_tx_o   (irq_tx_o),
      .irq_brk_o  (irq_brk_o),
      .irq_err_o  (irq_err_o)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      tick();
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic t_reset();
      chk("R1", "status", status_o, 8'h60);
      chk("R1", "line", line_o, 0);
      chk("R1", "fctl", fctl_o, 0);
      chk("R1", "flush", rx_flush_o, 0);
      chk("R1", "irqs", {irq_rx_o, irq_tx_o, irq_brk_o, irq_err_o}, 0);
   endtask

   task automatic t_write_clear();
      brk_evt = 1; fer_evt = 1; per_evt = 1;
      tick();
      brk_evt = 0; fer_evt = 0; per_evt = 0;
      chk("R2", "events set", status_o, 8'hFC);
      wr(2'd0, 8'hFF);
      chk("R2", "ones keep", status_o, 8'hFC);
      wr(2'd0, 8'hEF);
      chk("R2", "clear break", status_o, 8'hEC);
      wr(2'd0, 8'h00);
      chk("R2", "clear all", status_o, 8'h20);
   endtask

   task automatic t_tend();
      tx_count = 5'd3; tick();
      tx_count = 5'd0; tick();
      chk("R3", "tend on drain", status_o[6], 1);
      tx_count = 5'd3; tick();
      wr(2'd0, 8'hBF);
      chk("R3", "tend held busy", status_o[6], 1);
      tx_count = 5'd0; tick();
      wr(2'd0, 8'hBF);
      chk("R3", "tend cleared", status_o[6], 0);
   endtask

   task automatic t_tdfe();
      tx_trig = 5'd4; tx_count = 5'd2; tick();
      wr(2'd0, 8'hDF);
      chk("R4", "tdfe held", status_o[5], 1);
      tx_count = 5'd8;
      wr(2'd0, 8'hDF);
      chk("R4", "tdfe cleared", status_o[5], 0);
      tx_count = 5'd4; tick();
      chk("R4", "tdfe at level", status_o[5], 1);
      tx_count = 5'd0; tx_trig = 5'd0; tick();
   endtask

   task automatic t_rdf();
      rx_trig = 5'd4; rx_count = 5'd3; tick();
      chk("R5", "rdf below", status_o[1], 0);
      rx_count = 5'd4; tick();
      chk("R5", "rdf at level", status_o[1], 1);
      wr(2'd0, 8'hFD);
      chk("R5", "rdf held", status_o[1], 1);
      rx_count = 5'd3;
      wr(2'd0, 8'hFD);
      chk("R5", "rdf cleared", status_o[1], 0);
      rx_count = 5'd0; tick();
   endtask

   task automatic t_dr();
      rx_count = 5'd2;
      rx_tmo_evt = 1; tick(); rx_tmo_evt = 0;
      chk("R6", "dr set", status_o[0], 1);
      wr(2'd0, 8'hFE);
      chk("R6", "dr held", status_o[0], 1);
      rx_count = 5'd0;
      wr(2'd0, 8'hFE);
      chk("R6", "dr cleared", status_o[0], 0);
   endtask

   task automatic t_prio();
      fer_evt = 1;
      wr(2'd0, 8'hF7);
      fer_evt = 0;
      chk("R7", "fer set wins", {status_o[7], status_o[3]}, 2'b11);
      wr(2'd0, 8'h73);
      chk("R7", "err bits cleared", status_o & 8'h8C, 0);
   endtask

   task automatic t_line();
      ovr_evt = 1; tick(); ovr_evt = 0;
      chk("R8", "orer set", line_o, 1);
      wr(2'd1, 8'hFF);
      chk("R8", "write one keeps", line_o, 1);
      wr(2'd1, 8'h00);
      chk("R8", "write zero clears", line_o, 0);
      wr(2'd1, 8'h01);
      chk("R8", "write one no set", line_o, 0);
      ovr_evt = 1;
      wr(2'd1, 8'h00);
      ovr_evt = 0;
      chk("R8", "event beats clear", line_o, 1);
      wr(2'd1, 8'h00);
      chk("R8", "cleared again", line_o, 0);
   endtask

   task automatic t_fctl();
      wr(2'd2, 8'hF4);
      chk("R9", "low bits kept", fctl_o, 4'h4);
      chk("R9", "no flush", rx_flush_o, 0);
      rx_trig = 5'd4; rx_count = 5'd5;
      rx_tmo_evt = 1; tick(); rx_tmo_evt = 0;
      chk("R9", "rx flags up", status_o[1:0], 2'b11);
      wr(2'd2, 8'h0A);
      chk("R9", "flush clears flags", status_o[1:0], 2'b00);
      chk("R9", "fctl stored", fctl_o, 4'hA);
      chk("R9", "flush strobe", rx_flush_o, 1);
      rx_count = 5'd0; tick();
      chk("R9", "strobe one cycle", rx_flush_o, 0);
      chk("R9", "flags stay clear", status_o[1:0], 2'b00);
   endtask

   task automatic t_irq_rx();
      rx_ie = 1; tick();
      chk("R10", "rx irq idle", irq_rx_o, 0);
      rx_count = 5'd1;
      rx_tmo_evt = 1; tick(); rx_tmo_evt = 0;
      chk("R10", "rx irq raised", irq_rx_o, 1);
      rx_ie = 0; rx_count = 5'd0;
      wr(2'd0, 8'hFE);
      chk("R10", "dr cleared", status_o[0], 0);
      chk("R10", "rx irq frozen", irq_rx_o, 1);
      rx_ie = 1; tick();
      chk("R10", "rx irq dropped", irq_rx_o, 0);
   endtask

   task automatic t_irq_tx();
      tx_trig = 5'd4; tx_count = 5'd0;
      tx_ie = 1; tick();
      chk("R11", "tx irq raised", irq_tx_o, 1);
      tx_count = 5'd8;
      wr(2'd0, 8'hDF);
      chk("R11", "tx irq dropped", irq_tx_o, 0);
      tx_ie = 0; tx_count = 5'd2; tick();
      chk("R11", "tdfe back", status_o[5], 1);
      chk("R11", "tx irq frozen", irq_tx_o, 0);
      tx_ie = 1; tick();
      chk("R11", "tx irq follows", irq_tx_o, 1);
      tx_ie = 0;
   endtask

   task automatic t_irq_err();
      err_ie = 1; tick();
      chk("R12", "err irqs idle", {irq_brk_o, irq_err_o}, 2'b00);
      brk_evt = 1; tick(); brk_evt = 0;
      chk("R12", "brk irq raised", {irq_brk_o, irq_err_o}, 2'b10);
      wr(2'd0, 8'hEF);
      chk("R12", "brk irq dropped", irq_brk_o, 0);
      ovr_evt = 1; tick(); ovr_evt = 0;
      chk("R12", "overrun irq", irq_err_o, 1);
      wr(2'd1, 8'h00);
      chk("R12", "overrun irq dropped", irq_err_o, 0);
      per_evt = 1; tick(); per_evt = 0;
      chk("R12", "parity irq", irq_err_o, 1);
      err_ie = 0;
      wr(2'd0, 8'h7B);
      chk("R12", "er cleared", status_o[7], 0);
      chk("R12", "err irq frozen", irq_err_o, 1);
      err_ie = 1; tick();
      chk("R12", "err irq dropped", irq_err_o, 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      tick(); tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_write_clear();
      t_tend();
      t_tdfe();
      t_rdf();
      t_dr();
      t_prio();
      t_line();
      t_fctl();
      t_irq_rx();
      t_irq_tx();
      t_irq_err();
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule